// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the uops that are in flight in a circular buffer of eight entries. The rename stage allocates one entry per uop, in program order. Each entry acts as the renamed register for the uop's result. It holds three things: the result value, a done flag that shows whether that value has arrived, and the architectural register that the result must finally update. Execution units return results on a writeback port. Each result carries the tag of the entry it belongs to. The rename stage can read the value and done flag of any tag through a combinational read port, so it can pick up results that have already completed.

The oldest entry retires once its result is done. At most one entry retires per cycle. Retirement drives the commit port with the entry's architectural register and value for the architectural register file. A flush input empties the buffer in one cycle, which discards all speculative work.

A small occupancy state machine tracks the buffer's fill level. Its three states are RB_EMPTY, RB_ACTIVE and RB_FULL. Its transitions are:
- First-fill: RB_EMPTY to RB_ACTIVE, on an allocation.
- Fill: RB_ACTIVE to RB_FULL, when an allocation without a retirement makes the tail reach the head.
- Drain: RB_ACTIVE to RB_EMPTY, when a retirement without an allocation makes the head reach the tail.
- Unfull: RB_FULL to RB_ACTIVE, on a retirement.
- Flush: any state to RB_EMPTY.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `alloc_ready`=1, `commit_valid`=0 and `alloc_tag`=0.
- R2: Accepted allocations receive tags in program order. `alloc_tag` is the tag the next accepted allocation will get, and it advances by one, modulo 8, on each accepted allocation.
- R3: With 8 live entries, `full`=1 and `alloc_ready`=0. While `full`=1, a raised `alloc_valid` leaves the tag and the occupancy unchanged.
- R4: A writeback to a live entry sets its done flag and stores `wb_data`. From the next cycle, the read port returns `rd_done`=1 and that value for the tag.
- R5: A writeback to a tag that is not live is ignored. `rd_done` stays 0 for that tag. If the tag is allocated later, it starts not done.
- R6: `commit_valid` is 1 only when the oldest live entry is done. A younger entry that is done never commits ahead of an older entry that is not done.
- R7: While `commit_valid`=1, `commit_areg` and `commit_data` show the oldest entry's destination and result. That entry is freed at the clock edge, so at most one entry retires per cycle.
- R8: An allocation and a retirement in the same cycle leave the number of live entries unchanged.
- R9: `flush`=1 forces `commit_valid`=0 and `alloc_ready`=0 in that cycle. From the next cycle the buffer is empty and the next tag is 0.
- R10: For a tag that is not live, the read port returns `rd_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard every entry |
| alloc_valid | input | 1 | Rename requests a new entry |
| alloc_areg | input | 3 | Architectural destination of the new uop |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | 3 | Tag given to the next accepted allocation |
| wb_valid | input | 1 | A result is on the writeback port |
| wb_tag | input | 3 | Entry the result belongs to |
| wb_data | input | 16 | Result value |
| rd_tag | input | 3 | Tag looked up by rename |
| rd_done | output | 1 | Looked-up entry is live and done |
| rd_data | output | 16 | Stored value of the looked-up entry |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_areg | output | 3 | Architectural register to update |
| commit_data | output | 16 | Value written to that register |
| full | output | 1 | All 8 entries are live |
| empty | output | 1 | No entry is live |

## Verification
Allocation and retirement can happen in the same cycle. Writeback and retirement can also meet: a writeback may target the head entry in the cycle before it retires, or target a tag in the very cycle that tag is freed or reallocated. The bench creates these collisions by completing the head entry while rename keeps allocating, including one case one entry short of full. It also raises flush together with an allocation. A behavioural queue model decides, every cycle, which event takes effect. All outputs are compared against that model, so a lost allocation, a double retirement or a stale done flag shows up as an output mismatch.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        RB_EMPTY  = 2'd0,
        RB_ACTIVE = 2'd1,
        RB_FULL   = 2'd2
    } rob_state_e;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_req,
    input  logic             head_done,
    output logic             alloc_fire,
    output logic             retire_fire,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

    rob_state_e state_q, state_d;
    logic [TAG_W-1:0] head_d, tail_d;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign alloc_fire  = alloc_req && (state_q != RB_FULL) && !flush;
    assign retire_fire = head_done && !flush;

    always_comb begin
        head_d  = retire_fire ? bump(head) : head;
        tail_d  = alloc_fire ? bump(tail) : tail;
        state_d = state_q;
        if (flush) begin
            state_d = RB_EMPTY;
            head_d  = '0;
            tail_d  = '0;
        end else begin
            unique case (state_q)
                RB_EMPTY:  if (alloc_fire) state_d = RB_ACTIVE;
                RB_ACTIVE: begin
                    if (alloc_fire && !retire_fire && tail_d == head)
                        state_d = RB_FULL;
                    else if (retire_fire && !alloc_fire && head_d == tail)
                        state_d = RB_EMPTY;
                end
                RB_FULL:   if (retire_fire) state_d = RB_ACTIVE;
                default:   state_d = RB_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_EMPTY;
            head    <= '0;
            tail    <= '0;
        end else begin
            state_q <= state_d;
            head    <= head_d;
            tail    <= tail_d;
        end
    end

    always_comb begin
        full  = (state_q == RB_FULL);
        empty = (state_q == RB_EMPTY);
    end
endmodule

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int DATA_W = 16,
    parameter int AREG_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          alloc_fire,
    input  logic [TAG_W-1:0]              tail,
    input  logic [AREG_W-1:0]             alloc_areg,
    input  logic                          retire_fire,
    input  logic [TAG_W-1:0]              head,
    input  logic                          wb_valid,
    input  logic [TAG_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_data,
    output logic [DEPTH-1:0]              live,
    output logic [DEPTH-1:0]              done,
    output logic [DEPTH-1:0][AREG_W-1:0]  areg,
    output logic [DEPTH-1:0][DATA_W-1:0]  data
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic is_tail, is_head, is_wb;
        assign is_tail = alloc_fire  && (tail == TAG_W'(i));
        assign is_head = retire_fire && (head == TAG_W'(i));
        assign is_wb   = wb_valid    && (wb_tag == TAG_W'(i)) && live[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[i] <= 1'b0;
                done[i] <= 1'b0;
                areg[i] <= '0;
                data[i] <= '0;
            end else if (flush) begin
                live[i] <= 1'b0;
                done[i] <= 1'b0;
            end else if (is_tail) begin
                live[i] <= 1'b1;
                done[i] <= 1'b0;
                areg[i] <= alloc_areg;
            end else if (is_head) begin
                live[i] <= 1'b0;
                done[i] <= 1'b0;
            end else if (is_wb) begin
                done[i] <= 1'b1;
                data[i] <= wb_data;
            end
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int AREG_W = 3,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic [AREG_W-1:0] alloc_areg,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              commit_valid,
    output logic [AREG_W-1:0] commit_areg,
    output logic [DATA_W-1:0] commit_data,
    output logic              full,
    output logic              empty
);
    logic alloc_fire, retire_fire, head_done;
    logic [TAG_W-1:0] head, tail;
    logic [DEPTH-1:0] live, done;
    logic [DEPTH-1:0][AREG_W-1:0] areg;
    logic [DEPTH-1:0][DATA_W-1:0] data;

    assign head_done = live[head] && done[head];

    rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
        .clk, .rst_n, .flush,
        .alloc_req(alloc_valid), .head_done,
        .alloc_fire, .retire_fire,
        .head, .tail, .full, .empty
    );

    rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_store (
        .clk, .rst_n, .flush,
        .alloc_fire, .tail, .alloc_areg,
        .retire_fire, .head,
        .wb_valid, .wb_tag, .wb_data,
        .live, .done, .areg, .data
    );

    assign alloc_ready  = !full && !flush;
    assign alloc_tag    = tail;
    assign rd_done      = live[rd_tag] && done[rd_tag];
    assign rd_data      = data[rd_tag];
    assign commit_valid = retire_fire;
    assign commit_areg  = areg[head];
    assign commit_data  = data[head];
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             commit_valid,
    input logic             full,
    input logic             empty
);
    // R3
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ready);
    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && alloc_tag == '0));
    // R6
    no_commit_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !commit_valid);
    // R2
    tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (alloc_tag == TAG_W'($past(alloc_tag) + 1'b1)));
    // R8
    alloc_retire_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && commit_valid) |=> (!empty && !full));
endmodule

bind rob_core rob_chk #(.TAG_W(TAG_W)) u_rob_chk (
    .clk, .rst_n, .flush, .alloc_valid, .alloc_ready, .alloc_tag,
    .commit_valid, .full, .empty
);

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, alloc_valid = 1'b0, wb_valid = 1'b0;
    logic [2:0] alloc_areg = '0, wb_tag = '0, rd_tag = '0;
    logic [15:0] wb_data = '0;
    logic alloc_ready, rd_done, commit_valid, full, empty;
    logic [2:0] alloc_tag, commit_areg;
    logic [15:0] rd_data, commit_data;

    always #2 clk = ~clk;

    rob_core dut (.*);

    int checks = 0, fails = 0;
    int q[$];
    bit m_live[N], m_done[N];
    int m_areg[N], m_data[N];
    int m_tail = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(bit av, int aa, bit wv, int wt, int wd, int rt, bit fl);
        bit e_ready, e_cv, e_rd;
        int retired;
        alloc_valid = av; alloc_areg = 3'(aa);
        wb_valid = wv; wb_tag = 3'(wt); wb_data = 16'(wd);
        rd_tag = 3'(rt); flush = fl;
        #1;
        e_ready = (q.size() < N) && !fl;
        e_cv    = !fl && q.size() > 0 && m_done[q[0]];
        e_rd    = m_live[rt] && m_done[rt];
        chk("R3 alloc_ready", int'(alloc_ready), int'(e_ready));
        chk("R3 full", int'(full), int'(q.size() == N));
        chk("R1 empty", int'(empty), int'(q.size() == 0));
        chk("R2 alloc_tag", int'(alloc_tag), m_tail);
        chk("R6 commit_valid", int'(commit_valid), int'(e_cv));
        if (e_cv) begin
            chk("R7 commit_areg", int'(commit_areg), m_areg[q[0]]);
            chk("R7 commit_data", int'(commit_data), m_data[q[0]]);
        end
        chk("R10 rd_done", int'(rd_done), int'(e_rd));
        if (e_rd) chk("R4 rd_data", int'(rd_data), m_data[rt]);
        @(posedge clk);
        if (fl) begin
            q.delete();
            foreach (m_live[i]) begin m_live[i] = 0; m_done[i] = 0; end
            m_tail = 0;
        end else begin
            retired = -1;
            if (e_cv) begin retired = q.pop_front(); m_live[retired] = 0; m_done[retired] = 0; end
            if (wv && m_live[wt]) begin m_done[wt] = 1; m_data[wt] = wd; end
            if (av && e_ready) begin
                q.push_back(m_tail); m_live[m_tail] = 1; m_done[m_tail] = 0;
                m_areg[m_tail] = aa; m_tail = (m_tail + 1) % N;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(int rt = 0);
        step(0, 0, 0, 0, 0, rt, 0);
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset empty", int'(empty), 1);
        chk("R1 reset commit_valid", int'(commit_valid), 0);
        chk("R1 reset alloc_tag", int'(alloc_tag), 0);
        idle();
        // R2 in-order allocation, R10 read of non-live tag
        step(1, 1, 0, 0, 0, 5, 0);
        step(1, 2, 0, 0, 0, 5, 0);
        step(1, 3, 0, 0, 0, 0, 0);
        // R6 younger done, head not done: no commit
        step(0, 0, 1, 1, 16'hAAAA, 1, 0);
        idle(1);
        // R5 writeback to unallocated tag 5 ignored
        step(0, 0, 1, 5, 16'h5555, 5, 0);
        idle(5);
        // R4/R7 complete head, then retire two in a row
        step(0, 0, 1, 0, 16'h1234, 0, 0);
        idle(0);
        idle(1);
        // R8 alloc while retiring (tag 2 completes then retires during alloc)
        step(0, 0, 1, 2, 16'h0BEE, 2, 0);
        step(1, 4, 0, 0, 0, 2, 0);
        // R3 fill to full
        for (int k = 0; k < 7; k++) step(1, k, 0, 0, 0, 3, 0);
        // R5 tag 5 allocated late starts not done
        idle(5);
        // R3 alloc while full ignored
        step(1, 6, 0, 0, 0, 0, 0);
        step(1, 6, 0, 0, 0, 0, 0);
        // R8 near full: complete head and alloc same cycle as retire
        step(0, 0, 1, 3, 16'h0033, 3, 0);
        step(1, 7, 1, 4, 16'h0044, 4, 0);
        step(1, 2, 0, 0, 0, 4, 0);
        // complete others out of order and drain
        for (int k = 7; k >= 0; k--) step(0, 0, 1, k, 16'h1000 + k, k, 0);
        for (int k = 0; k < 10; k++) idle(k % N);
        // R9 flush mid-flight, with alloc in same cycle
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 2, 1, 1, 16'h7777, 1, 0);
        step(1, 3, 0, 0, 0, 1, 1);
        chk("R9 empty after flush", int'(empty), 1);
        chk("R9 tag restart", int'(alloc_tag), 0);
        idle(1);
        step(1, 5, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 16'h00FF, 0, 0);
        idle(0);
        idle(0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule